// File: doc/BRIEF.md
# Page Table Walk Step Unit

This unit carries out the two hardware-assisted steps of a software-managed page-table walk. A directory step takes the current base (a table address or a huge-page entry) and a walk level, and yields the base for the next level. A leaf step takes a base and an odd/even selector, and produces one half of a refill entry pair together with the refill page size. Directory and leaf indices are cut out of the faulting virtual address using per-level shift/width settings and a separate leaf shift/width.

A step is offered on a valid/ready command port. `cmd_ready` is high only while no step is in progress, so a command waits with `cmd_valid` held until the unit is idle. A step that needs memory issues exactly one 64-bit read on the request port and holds its address until `mem_req_ready` is seen. The response arrives later as a one-cycle `mem_rsp_valid` beat with no back-pressure. Every accepted step ends in a one-cycle `step_done` pulse with `step_result`. A leaf step also updates the even or odd refill register and the refill page-size output. Huge-page entries never cause a read: the directory step tags them with their level, and the leaf step splits them into an even and an odd half.

Top module: `ptw_step_unit`

## Requirements
- R1: A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from acceptance until the step completes, so at most one read is outstanding. `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is sampled high.
- R2: A directory step whose level is 0 or above NUM_LVL returns `cmd_base` unchanged, issues no read, and pulses `step_done` in the cycle after acceptance.
- R3: A directory step on a base with the huge bit (bit 6) set issues no read. If the level equals NUM_LVL, or the level field (bits 14:13) is nonzero, the base is returned unchanged. Otherwise the base is returned with the level written into bits 14:13.
- R4: A non-huge directory step at level L reads address (base masked to PA_W bits) OR (((badv >> shift_L) masked to width_L bits) << 3). shift_L and width_L are 6-bit fields at slot L-1 of `cfg_dir_shift` and `cfg_dir_width`, i.e. bits [6(L-1)+5 : 6(L-1)].
- R5: A step that reads memory returns the response data masked to PA_W bits, with `step_done` one cycle after the response beat.
- R6: A non-huge leaf step forms an index as (badv >> `cfg_pte_shift`) masked to `cfg_pte_width` bits, with bit 0 cleared. The even step reads base|(index<<3) and the odd step reads base|((index+1)<<3). The masked data goes to `refill_lo1` if odd and to `refill_lo0` otherwise, and `refill_ps` becomes `cfg_pte_shift`.
- R7: A leaf step on a huge base (after PA masking, bit 6 set) issues no read. It clears bits 14:13 and bit 6. Its page size is shift+width-1 of the level recorded in bits 14:13, and the odd half adds 1<<ps to the entry.
- R8: In a huge leaf step with the huge-global bit 12 set, bit 12 is cleared and the global bit 6 is set in the result.
- R9: A directory step leaves `refill_lo0`, `refill_lo1` and `refill_ps` unchanged. A leaf step leaves the refill register of the other parity unchanged.
- R10: After reset `step_done`, `mem_req_valid`, `step_result`, `refill_lo0`, `refill_lo1` and `refill_ps` are zero and `cmd_ready` is high.
- R11: Each accepted command yields exactly one `step_done` pulse, which occurs while `cmd_ready` is high. `step_result` carries the value produced by that step and changes only with `step_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Step command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_is_pte | input | 1 | 1: leaf step, 0: directory step |
| cmd_base | input | 64 | Table base or huge-page entry |
| cmd_level | input | LVL_IN_W | Directory level |
| cmd_odd | input | 1 | Leaf step selects odd half |
| refill_badv | input | VA_W | Faulting virtual address |
| cfg_dir_shift | input | NUM_LVL*SH_W | Per-level index shift, level L at slot L-1 |
| cfg_dir_width | input | NUM_LVL*SH_W | Per-level index width, level L at slot L-1 |
| cfg_pte_shift | input | SH_W | Leaf index shift |
| cfg_pte_width | input | SH_W | Leaf index width |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 64 | Read data |
| step_done | output | 1 | One-cycle completion pulse |
| step_result | output | 64 | Value produced by the last step |
| refill_lo0 | output | 64 | Even refill entry |
| refill_lo1 | output | 64 | Odd refill entry |
| refill_ps | output | SH_W | Refill page size |

## Verification
A step that needs no read (illegal level, huge directory, huge leaf) finishes one cycle after acceptance. A reading step raises its request in the cycle after acceptance, holds it for as many cycles as the memory withholds ready, and finishes one cycle after the response beat. The bench records the acceptance cycle and the response cycle. It samples outputs on the falling edge and compares the cycle of each `step_done` against those two marks. The memory model varies its ready and response delays, so the latency rules are checked under back-pressure.

// File: rtl/ptw_step_pkg.sv
package ptw_step_pkg;
  localparam int unsigned WORD_W = 64;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ptw_state_e;
endpackage

// File: rtl/ptw_dir_calc.sv
module ptw_dir_calc #(
  parameter int unsigned PA_W     = 48,
  parameter int unsigned VA_W     = 48,
  parameter int unsigned NUM_LVL  = 4,
  parameter int unsigned SH_W     = 6,
  parameter int unsigned LVL_IN_W = 3,
  parameter int unsigned HUGE_BIT = 6,
  parameter int unsigned LVL_LSB  = 13,
  parameter int unsigned LVL_W    = 2
) (
  input  logic [ptw_step_pkg::WORD_W-1:0] base,
  input  logic [LVL_IN_W-1:0]             level,
  input  logic [VA_W-1:0]                 badv,
  input  logic [NUM_LVL*SH_W-1:0]         cfg_shift,
  input  logic [NUM_LVL*SH_W-1:0]         cfg_width,
  output logic                            bypass,
  output logic [ptw_step_pkg::WORD_W-1:0] bypass_val,
  output logic [ptw_step_pkg::WORD_W-1:0] rd_addr
);
  localparam int unsigned W     = ptw_step_pkg::WORD_W;
  localparam int unsigned SEL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam logic [W-1:0] PA_MASK = {{(W-PA_W){1'b0}}, {PA_W{1'b1}}};
  localparam logic [LVL_IN_W-1:0] LVL_MAX = LVL_IN_W'(NUM_LVL);

  logic             lvl_ok;
  logic             huge;
  logic [SEL_W-1:0] sel;
  logic [SH_W-1:0]  shift;
  logic [SH_W-1:0]  width;
  logic [W-1:0]     idx;

  always_comb begin
    lvl_ok = (level != '0) && (level <= LVL_MAX);
    huge   = base[HUGE_BIT];
    sel    = SEL_W'(level - 1'b1);
    shift  = cfg_shift[int'(sel)*SH_W +: SH_W];
    width  = cfg_width[int'(sel)*SH_W +: SH_W];
    idx    = (W'(badv) >> shift) & ~({W{1'b1}} << width);
    rd_addr = (base & PA_MASK) | (idx << 3);

    bypass     = !lvl_ok || huge;
    bypass_val = base;
    if (lvl_ok && huge && (level != LVL_MAX) &&
        (base[LVL_LSB +: LVL_W] == '0)) begin
      bypass_val[LVL_LSB +: LVL_W] = level[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/ptw_pte_calc.sv
module ptw_pte_calc #(
  parameter int unsigned PA_W     = 48,
  parameter int unsigned VA_W     = 48,
  parameter int unsigned NUM_LVL  = 4,
  parameter int unsigned SH_W     = 6,
  parameter int unsigned HUGE_BIT = 6,
  parameter int unsigned GLB_BIT  = 6,
  parameter int unsigned HGLB_BIT = 12,
  parameter int unsigned LVL_LSB  = 13,
  parameter int unsigned LVL_W    = 2
) (
  input  logic [ptw_step_pkg::WORD_W-1:0] base,
  input  logic                            odd,
  input  logic [VA_W-1:0]                 badv,
  input  logic [NUM_LVL*SH_W-1:0]         cfg_shift,
  input  logic [NUM_LVL*SH_W-1:0]         cfg_width,
  input  logic [SH_W-1:0]                 pte_shift,
  input  logic [SH_W-1:0]                 pte_width,
  output logic                            huge,
  output logic [ptw_step_pkg::WORD_W-1:0] huge_val,
  output logic [ptw_step_pkg::WORD_W-1:0] rd_addr,
  output logic [SH_W-1:0]                 ps_out
);
  localparam int unsigned W     = ptw_step_pkg::WORD_W;
  localparam int unsigned SEL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam logic [W-1:0] PA_MASK = {{(W-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic [W-1:0]     b;
  logic [LVL_W-1:0] rec_lvl;
  logic [LVL_W-1:0] lvl_m1;
  logic [SEL_W-1:0] sel;
  logic [SH_W-1:0]  huge_ps;
  logic [W-1:0]     split;
  logic [W-1:0]     pti;
  logic [W-1:0]     offs;

  always_comb begin
    b       = base & PA_MASK;
    huge    = b[HUGE_BIT];
    rec_lvl = b[LVL_LSB +: LVL_W];
    lvl_m1  = (rec_lvl == '0) ? '0 : rec_lvl - 1'b1;
    sel     = SEL_W'(lvl_m1);
    huge_ps = cfg_shift[int'(sel)*SH_W +: SH_W] +
              cfg_width[int'(sel)*SH_W +: SH_W] - 1'b1;

    split = b;
    split[LVL_LSB +: LVL_W] = '0;
    split[HUGE_BIT]         = 1'b0;
    if (b[HGLB_BIT]) begin
      split[HGLB_BIT] = 1'b0;
      split[GLB_BIT]  = 1'b1;
    end
    huge_val = odd ? (split + ({{(W-1){1'b0}}, 1'b1} << huge_ps)) : split;

    pti     = (W'(badv) >> pte_shift) & ~({W{1'b1}} << pte_width);
    pti[0]  = 1'b0;
    offs    = odd ? ((pti + 1'b1) << 3) : (pti << 3);
    rd_addr = b | offs;
    ps_out  = huge ? huge_ps : pte_shift;
  end
endmodule

// File: rtl/ptw_step_unit.sv
module ptw_step_unit #(
  parameter int unsigned PA_W     = 48,
  parameter int unsigned VA_W     = 48,
  parameter int unsigned NUM_LVL  = 4,
  parameter int unsigned SH_W     = 6,
  parameter int unsigned LVL_IN_W = 3,
  parameter int unsigned HUGE_BIT = 6,
  parameter int unsigned GLB_BIT  = 6,
  parameter int unsigned HGLB_BIT = 12,
  parameter int unsigned LVL_LSB  = 13,
  parameter int unsigned LVL_W    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_is_pte,
  input  logic [63:0]             cmd_base,
  input  logic [LVL_IN_W-1:0]     cmd_level,
  input  logic                    cmd_odd,
  input  logic [VA_W-1:0]         refill_badv,
  input  logic [NUM_LVL*SH_W-1:0] cfg_dir_shift,
  input  logic [NUM_LVL*SH_W-1:0] cfg_dir_width,
  input  logic [SH_W-1:0]         cfg_pte_shift,
  input  logic [SH_W-1:0]         cfg_pte_width,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [63:0]             mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [63:0]             mem_rsp_data,
  output logic                    step_done,
  output logic [63:0]             step_result,
  output logic [63:0]             refill_lo0,
  output logic [63:0]             refill_lo1,
  output logic [SH_W-1:0]         refill_ps
);
  import ptw_step_pkg::*;
  localparam int unsigned W = WORD_W;
  localparam logic [W-1:0] PA_MASK = {{(W-PA_W){1'b0}}, {PA_W{1'b1}}};

  ptw_state_e      state_q;
  logic [W-1:0]    addr_q;
  logic            is_pte_q;
  logic            odd_q;
  logic [SH_W-1:0] ps_q;
  logic            done_q;
  logic [W-1:0]    result_q;
  logic [W-1:0]    lo0_q;
  logic [W-1:0]    lo1_q;
  logic [SH_W-1:0] rps_q;

  logic            dir_bypass;
  logic [W-1:0]    dir_bypass_val;
  logic [W-1:0]    dir_addr;
  logic            pte_huge;
  logic [W-1:0]    pte_huge_val;
  logic [W-1:0]    pte_addr;
  logic [SH_W-1:0] pte_ps;
  logic            accept;
  logic [W-1:0]    rsp_masked;

  ptw_dir_calc #(
    .PA_W(PA_W), .VA_W(VA_W), .NUM_LVL(NUM_LVL), .SH_W(SH_W),
    .LVL_IN_W(LVL_IN_W), .HUGE_BIT(HUGE_BIT), .LVL_LSB(LVL_LSB), .LVL_W(LVL_W)
  ) dir_i (
    .base(cmd_base), .level(cmd_level), .badv(refill_badv),
    .cfg_shift(cfg_dir_shift), .cfg_width(cfg_dir_width),
    .bypass(dir_bypass), .bypass_val(dir_bypass_val), .rd_addr(dir_addr)
  );

  ptw_pte_calc #(
    .PA_W(PA_W), .VA_W(VA_W), .NUM_LVL(NUM_LVL), .SH_W(SH_W),
    .HUGE_BIT(HUGE_BIT), .GLB_BIT(GLB_BIT), .HGLB_BIT(HGLB_BIT),
    .LVL_LSB(LVL_LSB), .LVL_W(LVL_W)
  ) pte_i (
    .base(cmd_base), .odd(cmd_odd), .badv(refill_badv),
    .cfg_shift(cfg_dir_shift), .cfg_width(cfg_dir_width),
    .pte_shift(cfg_pte_shift), .pte_width(cfg_pte_width),
    .huge(pte_huge), .huge_val(pte_huge_val), .rd_addr(pte_addr), .ps_out(pte_ps)
  );

  assign cmd_ready     = (state_q == ST_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign rsp_masked    = mem_rsp_data & PA_MASK;
  assign step_done     = done_q;
  assign step_result   = result_q;
  assign refill_lo0    = lo0_q;
  assign refill_lo1    = lo1_q;
  assign refill_ps     = rps_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      is_pte_q <= 1'b0;
      odd_q    <= 1'b0;
      ps_q     <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      lo0_q    <= '0;
      lo1_q    <= '0;
      rps_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            is_pte_q <= cmd_is_pte;
            odd_q    <= cmd_odd;
            ps_q     <= pte_ps;
            if (!cmd_is_pte) begin
              if (dir_bypass) begin
                done_q   <= 1'b1;
                result_q <= dir_bypass_val;
              end else begin
                addr_q  <= dir_addr;
                state_q <= ST_REQ;
              end
            end else if (pte_huge) begin
              done_q   <= 1'b1;
              result_q <= pte_huge_val;
              rps_q    <= pte_ps;
              if (cmd_odd) lo1_q <= pte_huge_val;
              else         lo0_q <= pte_huge_val;
            end else begin
              addr_q  <= pte_addr;
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            done_q   <= 1'b1;
            result_q <= rsp_masked;
            state_q  <= ST_IDLE;
            if (is_pte_q) begin
              rps_q <= ps_q;
              if (odd_q) lo1_q <= rsp_masked;
              else       lo0_q <= rsp_masked;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_step_chk.sv
module ptw_step_chk #(
  parameter int unsigned SH_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [63:0]     mem_req_addr,
  input logic            step_done,
  input logic [63:0]     step_result,
  input logic [63:0]     refill_lo0,
  input logic [63:0]     refill_lo1,
  input logic [SH_W-1:0] refill_ps
);
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r1_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);

  a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> cmd_ready);

  a_r11_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_result) |-> step_done);

  a_r9_lo0_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refill_lo0) |-> step_done);

  a_r9_lo1_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refill_lo1) |-> step_done);

  a_r9_ps_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refill_ps) |-> step_done);
endmodule

bind ptw_step_unit ptw_step_chk #(.SH_W(SH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .step_done(step_done),
  .step_result(step_result), .refill_lo0(refill_lo0),
  .refill_lo1(refill_lo1), .refill_ps(refill_ps)
);

// File: tb/ptw_step_unit_tb_top.sv
module ptw_step_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 48;
  localparam int VA_W = 48;
  localparam int NLVL = 4;
  localparam int SH_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_is_pte = 1'b0;
  logic [63:0] cmd_base = '0;
  logic [2:0] cmd_level = '0;
  logic cmd_odd = 1'b0;
  logic [VA_W-1:0] refill_badv = '0;
  logic [NLVL*SH_W-1:0] cfg_dir_shift = '0;
  logic [NLVL*SH_W-1:0] cfg_dir_width = '0;
  logic [SH_W-1:0] cfg_pte_shift = 6'd14;
  logic [SH_W-1:0] cfg_pte_width = 6'd11;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic step_done;
  logic [63:0] step_result, refill_lo0, refill_lo1;
  logic [SH_W-1:0] refill_ps;

  ptw_step_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_pte(cmd_is_pte), .cmd_base(cmd_base), .cmd_level(cmd_level),
    .cmd_odd(cmd_odd), .refill_badv(refill_badv),
    .cfg_dir_shift(cfg_dir_shift), .cfg_dir_width(cfg_dir_width),
    .cfg_pte_shift(cfg_pte_shift), .cfg_pte_width(cfg_pte_width),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .step_done(step_done),
    .step_result(step_result), .refill_lo0(refill_lo0),
    .refill_lo1(refill_lo1), .refill_ps(refill_ps)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [63:0] result;
    logic [63:0] lo0;
    logic [63:0] lo1;
    logic [5:0]  ps;
    bit          no_mem;
    int          acc_cycle;
    int          req_at;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] addr_q[$];
  int n_tests = 0, n_fail = 0, cyc = 0, req_count = 0, rsp_cycle = 0;
  int dly = 0;
  logic [63:0] m_lo0 = '0, m_lo1 = '0;
  logic [5:0]  m_ps = '0;
  int sh[4] = '{25, 36, 47, 20};
  int wd[4] = '{11, 11, 1, 9};
  localparam logic [63:0] PM = (64'd1 << PA_W) - 64'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid && mem_req_ready) req_count <= req_count + 1;
  end

  function automatic logic [63:0] lowmask(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] memdata(logic [63:0] a);
    return {a[31:0] ^ 32'hDEADBEEF, ~a[31:0]};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(exp_t e, bit is_pte, logic [63:0] base, logic [2:0] lvl, bit odd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_pte = is_pte; cmd_base = base;
    cmd_level = lvl; cmd_odd = odd;
    e.acc_cycle = cyc;
    e.req_at = req_count;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_dir(string req, logic [63:0] base, logic [2:0] lvl);
    exp_t e;
    logic [63:0] a, idx;
    e.lo0 = m_lo0; e.lo1 = m_lo1; e.ps = m_ps; e.req = req;
    if (lvl == 0 || lvl > 4) begin
      e.no_mem = 1; e.result = base;
    end else if (base[6]) begin
      e.no_mem = 1; e.result = base;
      if (lvl != 4 && base[14:13] == 2'b00) e.result[14:13] = lvl[1:0];
    end else begin
      e.no_mem = 0;
      idx = (64'(refill_badv) >> sh[lvl-1]) & lowmask(wd[lvl-1]);
      a = (base & PM) | (idx << 3);
      addr_q.push_back(a);
      e.result = memdata(a) & PM;
    end
    issue(e, 1'b0, base, lvl, 1'b0);
  endtask

  task automatic do_pte(string req, logic [63:0] base, bit odd);
    exp_t e;
    logic [63:0] b, v, pti, a;
    int s, ps;
    e.req = req;
    b = base & PM;
    if (b[6]) begin
      s = (b[14:13] == 0) ? 0 : int'(b[14:13]) - 1;
      ps = sh[s] + wd[s] - 1;
      v = b; v[14:13] = 2'b00; v[6] = 1'b0;
      if (b[12]) begin v[12] = 1'b0; v[6] = 1'b1; end
      if (odd) v = v + (64'd1 << ps);
      e.no_mem = 1;
    end else begin
      pti = (64'(refill_badv) >> cfg_pte_shift) & lowmask(int'(cfg_pte_width));
      pti[0] = 1'b0;
      a = b | (odd ? ((pti + 1) << 3) : (pti << 3));
      addr_q.push_back(a);
      v = memdata(a) & PM;
      ps = int'(cfg_pte_shift);
      e.no_mem = 0;
    end
    if (odd) m_lo1 = v; else m_lo0 = v;
    m_ps = ps[5:0];
    e.result = v; e.lo0 = m_lo0; e.lo1 = m_lo1; e.ps = m_ps;
    issue(e, 1'b1, base, 3'd0, odd);
  endtask

  // monitor: pops expected items on each completion pulse
  always @(negedge clk) begin
    if (rst_n && step_done) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11 extra done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "result", step_result, e.result);
        check("R9", "lo0", refill_lo0, e.lo0);
        check("R9", "lo1", refill_lo1, e.lo1);
        check("R9", "ps", 64'(refill_ps), 64'(e.ps));
        if (e.no_mem) begin
          check("R2", "no-read latency", 64'(cyc), 64'(e.acc_cycle + 1));
          check("R3", "no read issued", 64'(req_count), 64'(e.req_at));
        end else begin
          check("R5", "read latency", 64'(cyc), 64'(rsp_cycle + 1));
          check("R1", "one read", 64'(req_count), 64'(e.req_at + 1));
        end
      end
    end
  end

  // memory model with varying ready and response delays
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [63:0] a, ea;
        check("R1", "ready low while busy", 64'(cmd_ready), 64'd0);
        dly = (dly + 1) % 3;
        repeat (dly) @(negedge clk);
        a = mem_req_addr;
        mem_req_ready = 1'b1;
        ea = (addr_q.size() != 0) ? addr_q.pop_front() : 64'hX;
        check("R4", "read address", a, ea);
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (dly) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = memdata(a);
        rsp_cycle = cyc;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NLVL; i++) begin
      cfg_dir_shift[i*SH_W +: SH_W] = sh[i][5:0];
      cfg_dir_width[i*SH_W +: SH_W] = wd[i][5:0];
    end
    refill_badv = 48'h9A3C_5E71_D2B8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "cmd_ready", 64'(cmd_ready), 64'd1);
    check("R10", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    check("R10", "step_done", 64'(step_done), 64'd0);
    check("R10", "step_result", step_result, 64'd0);
    check("R10", "lo0", refill_lo0, 64'd0);
    check("R10", "lo1", refill_lo1, 64'd0);
    check("R10", "ps", 64'(refill_ps), 64'd0);

    // R2 illegal levels
    do_dir("R2", 64'h0000_1234_5678_0000, 3'd0);
    do_dir("R2", 64'h0000_1234_5678_0000, 3'd5);
    // R3 huge directory cases
    do_dir("R3", 64'h0000_0040_0000_0040, 3'd4);
    do_dir("R3", 64'h0000_0040_0000_2040, 3'd2);
    do_dir("R3", 64'h0000_0040_0000_0040, 3'd3);
    // R4/R5 normal directory reads
    do_dir("R4", 64'hFF00_0000_1234_0000, 3'd1);
    do_dir("R4", 64'h0000_0000_0080_0000, 3'd2);
    do_dir("R5", 64'h0000_0000_00A0_0000, 3'd4);
    // R6 leaf reads
    do_pte("R6", 64'h0000_0000_0300_0000, 1'b0);
    do_pte("R6", 64'h0000_0000_0300_0000, 1'b1);
    // R7/R8 huge leaf
    do_pte("R8", 64'h0000_4000_0000_5043, 1'b0);
    do_pte("R7", 64'h1000_4000_0000_4043, 1'b1);
    // R9 directory after leaf leaves refill state alone
    refill_badv = 48'h0123_4567_89AB;
    do_dir("R9", 64'h0000_0000_0500_0000, 3'd3);
    do_pte("R6", 64'h0000_0000_0700_0000, 1'b0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule